// File: doc/BRIEF.md
# Interrupt enable and flag register bank

This block is a small byte-wide register bank on a processor's local bus. It holds four registers at addresses 0 to 3. Address 0 holds the system interrupt enables and address 1 holds the serial port enables. Address 2 holds the system interrupt flags and address 3 holds the serial port flags. Peripherals outside the block raise the flags through single-cycle event pulses. Software reads the flags, clears them or sets them through plain bus writes.

The block has two reset levels. A power-on reset initialises every bit. A lighter power-up clear reinitialises most bits but leaves the reset-cause flags alone. After any restart, software can therefore tell a power-on, a reset-pin event and a watchdog event apart. Every resettable bit follows its own rule: it is cleared, it is forced to 1, or it is kept. Both resets are synchronous and active high. A power-on reset always implies a power-up clear.

The block drives seven interrupt request lines. Each line is the registered AND of a flag and its enable. The watchdog line is additionally gated by the watchdog's interval-timer mode. Vectoring and priority are handled outside the block.

Top module: `irq_regbank`

## Requirements
- R1: In the cycle after a power-on reset, every enable reads 0. The system flags read 0x06, meaning the power-on flag and the oscillator flag are set. The serial flags read 0x0A, meaning both transmit flags are set. All request lines are 0.
- R2: A power-up clear without a power-on reset has these effects. It clears all enables and the NMI flag. It forces the oscillator flag to 1. It loads the serial flags with 0x0A. It keeps the watchdog, power-on and reset-pin flags unchanged.
- R3: Bus writes store into the implemented bits only, and reads return those bits.
  - Address 0 implements bits 5, 4, 1 and 0: flash violation, NMI, oscillator and watchdog enables. Read mask 0x33.
  - Address 1 implements bits 3 to 0: serial B transmit, serial B receive, serial A transmit and serial A receive. Read mask 0x0F.
  - Address 2 implements bit 4 (NMI), bit 3 (reset pin), bit 2 (power-on), bit 1 (oscillator) and bit 0 (watchdog). Read mask 0x1F.
  - Address 3 implements the same four bits as address 1. Read mask 0x0F.
  - Every other bit reads 0.
- R4: Event pulses set flags in the next cycle.
  - A watchdog overflow or a key violation sets system bit 0.
  - An oscillator fault sets bit 1.
  - An NMI edge sets bit 4.
  - serialEvt[i] sets serial flag bit i.
- R5: A reset-pin event sets system bit 3 and clears the watchdog flag (bit 0). If a watchdog event arrives in the same cycle, the watchdog flag is set instead.
- R6: When an event pulse and a bus write hit the same flag in one cycle, the flag ends at 1.
- R7: One cycle after the flags and enables change, the request lines show the new state.
  - irqReq[6:3] = serial enables AND serial flags.
  - irqReq[2] = NMI enable AND NMI flag.
  - irqReq[1] = oscillator enable AND oscillator flag.
- R8: irqReq[0] is the watchdog enable AND the watchdog flag AND interval mode. It stays 0 whenever wdtIntervalMode was 0 in the previous cycle.
- R9: Bus writes made while either reset is asserted have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on reset, synchronous, active high |
| pucRst | input | 1 | Power-up clear, synchronous, active high |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register, combinational |
| wdtIntervalMode | input | 1 | 1 when the watchdog runs as an interval timer |
| wdtOverflow | input | 1 | Watchdog overflow pulse |
| wdtKeyViolation | input | 1 | Watchdog security key violation pulse |
| oscFault | input | 1 | Oscillator fault pulse |
| nmiEdge | input | 1 | NMI pin edge pulse |
| rstPinReset | input | 1 | Reset-pin reset event pulse |
| serialEvt | input | 4 | Serial flag set pulses, bit order as the serial flag register |
| irqReq | output | 7 | Registered interrupt request lines |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a software write to a flag register and a hardware set pulse on the same bit. The second pair is a reset-pin event and a watchdog event, which act in opposite directions on the watchdog flag. The bench provokes both pairs by driving the write and the pulse, or the two pulses, on the same clock edge. It then reads the register back and requires the set to prevail. Writes issued while a reset is held are checked the same way: the targeted bits are read afterwards and must be unchanged.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
  localparam int SYS_FLAGS = 5;
  localparam int SER_BITS  = 4;
  localparam int NUM_IRQ   = 3 + SER_BITS;

  // system register bit positions (enables at address 0, flags at address 2)
  localparam int POS_WDT  = 0;
  localparam int POS_OSC  = 1;
  localparam int POS_PWR  = 2;
  localparam int POS_PIN  = 3;
  localparam int POS_NMI  = 4;
  localparam int POS_FLSH = 5;

  localparam logic [SYS_FLAGS-1:0] PWRON_SYS = 5'b00110;
  localparam logic [SER_BITS-1:0]  CLEAR_SER = 4'b1010;

  typedef struct packed {
    logic hardInit;   // power-on reset
    logic softInit;   // power-up clear, also raised by power-on
    logic wrIeSys;
    logic wrIeSer;
    logic wrIfgSys;
    logic wrIfgSer;
  } bankStrobes_t;
endpackage

// File: rtl/irq_regbank_ctrl.sv
module irq_regbank_ctrl
  import irq_regbank_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              porRst,
  input  logic              pucRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output bankStrobes_t      strobes
);
  logic busWr;
  assign busWr = wrEn && !pucRst && !porRst;

  always_comb begin
    strobes          = '0;
    strobes.hardInit = porRst;
    strobes.softInit = porRst || pucRst;
    strobes.wrIeSys  = busWr && (addr == ADDR_W'(0));
    strobes.wrIeSer  = busWr && (addr == ADDR_W'(1));
    strobes.wrIfgSys = busWr && (addr == ADDR_W'(2));
    strobes.wrIfgSer = busWr && (addr == ADDR_W'(3));
  end
endmodule

// File: rtl/irq_regbank_dp.sv
module irq_regbank_dp
  import irq_regbank_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  bankStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 wdtIntervalMode,
  input  logic                 wdtOverflow,
  input  logic                 wdtKeyViolation,
  input  logic                 oscFault,
  input  logic                 nmiEdge,
  input  logic                 rstPinReset,
  input  logic [SER_BITS-1:0]  serialEvt,
  output logic [3:0]           ieSys,
  output logic [SYS_FLAGS-1:0] ifgSys,
  output logic [SER_BITS-1:0]  ieSer,
  output logic [SER_BITS-1:0]  ifgSer,
  output logic [NUM_IRQ-1:0]   irqReq
);
  // ieSys packing: [3] flash, [2] nmi, [1] osc, [0] watchdog
  logic [3:0]           ieSysN;
  logic [SYS_FLAGS-1:0] ifgSysN;
  logic [SER_BITS-1:0]  ieSerN, ifgSerN;
  logic [NUM_IRQ-1:0]   irqN;

  always_comb begin
    ieSysN  = ieSys;
    ieSerN  = ieSer;
    ifgSysN = ifgSys;
    ifgSerN = ifgSer;
    if (strobes.wrIeSys)
      ieSysN = {wrData[POS_FLSH], wrData[POS_NMI], wrData[POS_OSC], wrData[POS_WDT]};
    if (strobes.wrIeSer)  ieSerN  = wrData[SER_BITS-1:0];
    if (strobes.wrIfgSys) ifgSysN = wrData[SYS_FLAGS-1:0];
    if (strobes.wrIfgSer) ifgSerN = wrData[SER_BITS-1:0];
    if (rstPinReset) begin
      ifgSysN[POS_WDT] = 1'b0;
      ifgSysN[POS_PIN] = 1'b1;
    end
    if (wdtOverflow || wdtKeyViolation) ifgSysN[POS_WDT] = 1'b1;
    if (oscFault) ifgSysN[POS_OSC] = 1'b1;
    if (nmiEdge)  ifgSysN[POS_NMI] = 1'b1;
    ifgSerN = ifgSerN | serialEvt;
    if (strobes.softInit) begin
      ieSysN           = '0;
      ieSerN           = '0;
      ifgSysN[POS_OSC] = 1'b1;
      ifgSysN[POS_NMI] = 1'b0;
      ifgSerN          = CLEAR_SER;
    end
    if (strobes.hardInit) ifgSysN = PWRON_SYS;
  end

  always_comb begin
    irqN = '0;
    if (!strobes.softInit) begin
      irqN[0] = ieSys[0] && ifgSys[POS_WDT] && wdtIntervalMode;
      irqN[1] = ieSys[1] && ifgSys[POS_OSC];
      irqN[2] = ieSys[2] && ifgSys[POS_NMI];
      irqN[NUM_IRQ-1:3] = ieSer & ifgSer;
    end
  end

  always_ff @(posedge clk) begin
    ieSys  <= ieSysN;
    ieSer  <= ieSerN;
    ifgSys <= ifgSysN;
    ifgSer <= ifgSerN;
    irqReq <= irqN;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(0): begin
        rdData[POS_FLSH] = ieSys[3];
        rdData[POS_NMI]  = ieSys[2];
        rdData[POS_OSC]  = ieSys[1];
        rdData[POS_WDT]  = ieSys[0];
      end
      ADDR_W'(1): rdData[SER_BITS-1:0]  = ieSer;
      ADDR_W'(2): rdData[SYS_FLAGS-1:0] = ifgSys;
      default:    rdData[SER_BITS-1:0]  = ifgSer;
    endcase
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              pucRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              wdtIntervalMode,
  input  logic              wdtOverflow,
  input  logic              wdtKeyViolation,
  input  logic              oscFault,
  input  logic              nmiEdge,
  input  logic              rstPinReset,
  input  logic [3:0]        serialEvt,
  output logic [6:0]        irqReq
);
  bankStrobes_t         strobes;
  logic [3:0]           ieSys;
  logic [SYS_FLAGS-1:0] ifgSys;
  logic [SER_BITS-1:0]  ieSer, ifgSer;

  irq_regbank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .porRst(porRst), .pucRst(pucRst), .addr(addr), .wrEn(wrEn), .strobes(strobes)
  );

  irq_regbank_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .strobes(strobes), .addr(addr), .wrData(wrData), .rdData(rdData),
    .wdtIntervalMode(wdtIntervalMode), .wdtOverflow(wdtOverflow),
    .wdtKeyViolation(wdtKeyViolation), .oscFault(oscFault), .nmiEdge(nmiEdge),
    .rstPinReset(rstPinReset), .serialEvt(serialEvt),
    .ieSys(ieSys), .ifgSys(ifgSys), .ieSer(ieSer), .ifgSer(ifgSer), .irqReq(irqReq)
  );
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk
  import irq_regbank_pkg::*;
(
  input logic                 clk,
  input logic                 porRst,
  input logic                 pucRst,
  input logic                 wdtIntervalMode,
  input logic                 wdtOverflow,
  input logic                 wdtKeyViolation,
  input logic                 oscFault,
  input logic                 nmiEdge,
  input logic                 rstPinReset,
  input logic [3:0]           ieSys,
  input logic [SYS_FLAGS-1:0] ifgSys,
  input logic [SER_BITS-1:0]  ieSer,
  input logic [SER_BITS-1:0]  ifgSer,
  input logic [6:0]           irqReq
);
  a_r1_poweron_state: assert property (@(posedge clk)
    porRst |=> (ifgSys == PWRON_SYS && ieSys == '0 && ieSer == '0 && ifgSer == CLEAR_SER
                && irqReq == '0));

  a_r2_pwr_flag_kept: assert property (@(posedge clk) disable iff (porRst)
    pucRst |=> $stable(ifgSys[POS_PWR]));

  a_r4_osc_sets: assert property (@(posedge clk) disable iff (porRst)
    (oscFault && !pucRst) |=> ifgSys[POS_OSC]);

  a_r5_pin_clears_wdt: assert property (@(posedge clk) disable iff (porRst)
    (rstPinReset && !wdtOverflow && !wdtKeyViolation) |=> (!ifgSys[POS_WDT] && ifgSys[POS_PIN]));

  a_r6_nmi_set_wins: assert property (@(posedge clk) disable iff (porRst)
    (nmiEdge && !pucRst) |=> ifgSys[POS_NMI]);

  a_r7_serial_req: assert property (@(posedge clk) disable iff (porRst || pucRst)
    1'b1 |=> (irqReq[6:3] == $past(ieSer & ifgSer)));

  a_r8_wdt_gated: assert property (@(posedge clk) disable iff (porRst)
    !wdtIntervalMode |=> !irqReq[0]);
endmodule

bind irq_regbank irq_regbank_chk chk_i (
  .clk(clk), .porRst(porRst), .pucRst(pucRst), .wdtIntervalMode(wdtIntervalMode),
  .wdtOverflow(wdtOverflow), .wdtKeyViolation(wdtKeyViolation), .oscFault(oscFault),
  .nmiEdge(nmiEdge), .rstPinReset(rstPinReset), .ieSys(ieSys), .ifgSys(ifgSys),
  .ieSer(ieSer), .ifgSer(ifgSer), .irqReq(irqReq)
);

// File: tb/irq_regbank_tb_top.sv
`timescale 1ns/1ps
module irq_regbank_tb_top;
  logic       clk = 1'b0;
  logic       porRst = 1'b1, pucRst = 1'b1;
  logic [1:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       wdtIntervalMode = 1'b0;
  logic       wdtOverflow = 1'b0, wdtKeyViolation = 1'b0, oscFault = 1'b0;
  logic       nmiEdge = 1'b0, rstPinReset = 1'b0;
  logic [3:0] serialEvt = '0;
  logic [6:0] irqReq;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  irq_regbank dut_i (
    .clk(clk), .porRst(porRst), .pucRst(pucRst), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .wdtIntervalMode(wdtIntervalMode),
    .wdtOverflow(wdtOverflow), .wdtKeyViolation(wdtKeyViolation), .oscFault(oscFault),
    .nmiEdge(nmiEdge), .rstPinReset(rstPinReset), .serialEvt(serialEvt), .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #0.5;
    check(req, rdData, exp);
  endtask

  task automatic readMask(input logic [1:0] a, output logic [7:0] m);
    case (a)
      2'd0: m = 8'h33;
      2'd1: m = 8'h0F;
      2'd2: m = 8'h1F;
      default: m = 8'h0F;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] m;
    repeat (3) @(negedge clk);
    porRst = 1'b0; pucRst = 1'b0;

    // R1 power-on state
    readCheck("R1 ie0", 2'd0, 8'h00);
    readCheck("R1 ie1", 2'd1, 8'h00);
    readCheck("R1 ifg0", 2'd2, 8'h06);
    readCheck("R1 ifg1", 2'd3, 8'h0A);
    check("R1 irq", {1'b0, irqReq}, 8'h00);

    // R3 exhaustive write/read over every register and data byte
    for (int a = 0; a < 4; a++) begin
      for (int d = 0; d < 256; d++) begin
        busWrite(a[1:0], d[7:0]);
        readMask(a[1:0], m);
        readCheck("R3 write/read", a[1:0], d[7:0] & m);
      end
    end

    // R2 power-up clear
    busWrite(2'd0, 8'hFF); busWrite(2'd1, 8'hFF);
    busWrite(2'd2, 8'hFF); busWrite(2'd3, 8'hFF);
    @(negedge clk); pucRst = 1'b1;
    @(negedge clk); pucRst = 1'b0;
    readCheck("R2 ie0", 2'd0, 8'h00);
    readCheck("R2 ie1", 2'd1, 8'h00);
    readCheck("R2 ifg0", 2'd2, 8'h0F);
    readCheck("R2 ifg1", 2'd3, 8'h0A);

    // R9 writes under reset are dropped
    @(negedge clk); pucRst = 1'b1; addr = 2'd1; wrData = 8'h0F; wrEn = 1'b1;
    @(negedge clk); addr = 2'd2; wrData = 8'h00;
    @(negedge clk); pucRst = 1'b0; wrEn = 1'b0;
    readCheck("R9 ie1 under clear", 2'd1, 8'h00);
    readCheck("R9 ifg0 under clear", 2'd2, 8'h0F);

    // R1 power-on again clears the reset-cause flags
    @(negedge clk); porRst = 1'b1; pucRst = 1'b1;
    @(negedge clk); porRst = 1'b0; pucRst = 1'b0;
    readCheck("R1 ifg0 after second power-on", 2'd2, 8'h06);

    // R4 event sets
    busWrite(2'd2, 8'h00);
    readCheck("R4 cleared", 2'd2, 8'h00);
    @(negedge clk); wdtOverflow = 1'b1; @(negedge clk); wdtOverflow = 1'b0;
    readCheck("R4 overflow", 2'd2, 8'h01);
    busWrite(2'd2, 8'h00);
    @(negedge clk); wdtKeyViolation = 1'b1; @(negedge clk); wdtKeyViolation = 1'b0;
    readCheck("R4 key violation", 2'd2, 8'h01);
    busWrite(2'd2, 8'h00);
    @(negedge clk); oscFault = 1'b1; @(negedge clk); oscFault = 1'b0;
    readCheck("R4 osc fault", 2'd2, 8'h02);
    busWrite(2'd2, 8'h00);
    @(negedge clk); nmiEdge = 1'b1; @(negedge clk); nmiEdge = 1'b0;
    readCheck("R4 nmi", 2'd2, 8'h10);
    for (int i = 0; i < 4; i++) begin
      busWrite(2'd3, 8'h00);
      @(negedge clk); serialEvt = 4'(1 << i); @(negedge clk); serialEvt = '0;
      readCheck("R4 serial", 2'd3, 8'(1 << i));
    end

    // R5 reset-pin event
    busWrite(2'd2, 8'h01);
    @(negedge clk); rstPinReset = 1'b1; @(negedge clk); rstPinReset = 1'b0;
    readCheck("R5 pin clears wdt", 2'd2, 8'h08);
    busWrite(2'd2, 8'h01);
    @(negedge clk); rstPinReset = 1'b1; wdtOverflow = 1'b1;
    @(negedge clk); rstPinReset = 1'b0; wdtOverflow = 1'b0;
    readCheck("R5 wdt set beats pin clear", 2'd2, 8'h09);

    // R6 hardware set beats a same-cycle write
    @(negedge clk); addr = 2'd2; wrData = 8'h00; wrEn = 1'b1; oscFault = 1'b1;
    @(negedge clk); wrEn = 1'b0; oscFault = 1'b0;
    readCheck("R6 osc vs write", 2'd2, 8'h02);
    @(negedge clk); addr = 2'd3; wrData = 8'h00; wrEn = 1'b1; serialEvt = 4'b0101;
    @(negedge clk); wrEn = 1'b0; serialEvt = '0;
    readCheck("R6 serial vs write", 2'd3, 8'h05);

    // R8 watchdog request gated by interval mode
    busWrite(2'd2, 8'h01);
    busWrite(2'd0, 8'h01);
    @(negedge clk);
    check("R8 watchdog mode", {7'b0, irqReq[0]}, 8'h00);
    wdtIntervalMode = 1'b1;
    @(negedge clk);
    check("R8 interval mode", {7'b0, irqReq[0]}, 8'h01);
    wdtIntervalMode = 1'b0;
    @(negedge clk);
    check("R8 back to watchdog mode", {7'b0, irqReq[0]}, 8'h00);

    // R7 one-cycle latency and oscillator / nmi lines
    busWrite(2'd0, 8'h12);
    busWrite(2'd2, 8'h12);
    check("R7 latency old value", {1'b0, irqReq}, 8'h00);
    @(negedge clk);
    check("R7 osc and nmi lines", {1'b0, irqReq}, 8'h06);

    // R7 sweep of serial enables against serial flags
    busWrite(2'd0, 8'h00);
    for (int e = 0; e < 16; e++) begin
      busWrite(2'd1, 8'(e));
      for (int f = 0; f < 16; f++) begin
        busWrite(2'd3, 8'(f));
        @(negedge clk);
        check("R7 serial lines", {1'b0, irqReq}, 8'((e & f) << 3));
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule